// File: doc/BRIEF.md
# Image Sensor Operating State Controller

This block tracks which operating state a global-shutter image sensor is in and decides, for every register access request, whether that access may go ahead. It follows the supply, the sensor's hard-reset pin, the completion of the reserved-register upload, and two software enables: one for the logic blocks and one for the sequencer. From the state it produces enable lines for the clock tree, the functional blocks and the frame sequencer.

Register requests come in on a valid/ready interface. The block never applies back-pressure: `req_ready` is always high, and a request counts as taken in every cycle where `req_valid` is high. One cycle later the block answers with a response pulse. A request that is granted is also passed on unchanged to the register file. A request that is refused raises an error pulse and is dropped. Downstream there is no ready, so the register file must take every forwarded access.

Top module: `sensor_state_ctrl`

## Requirements
- R1: While `rst_n` is low, the state code is 0 (off), all enables are low, and no response or forwarded access is produced.
- R2: In the off state (code 0), every request is answered with `rsp_err` high. If `pwr_good` is low in any state, the next state is off.
- R3: In the off state with `pwr_good` high, the next state is limited standby (code 1). In this state only addresses below `LOW_LIMIT` (default 40) are granted, and addresses at or above the limit are rejected.
- R4: In any powered state (codes 1 to 5), `hard_rst` high moves the block to default standby (code 2). That state grants only addresses below `LOW_LIMIT`. `upload_done` has no effect in limited standby.
- R5: In default standby, `upload_done` high moves the block to full standby (code 3). In codes 3, 4 and 5 every address is granted.
- R6: In full standby, `logic_en` high moves the block to idle (code 4). In idle, `logic_en` low returns it to full standby. `seq_en` has no effect in full standby.
- R7: In idle with `logic_en` high, `seq_en` high moves the block to running (code 5). In running, `seq_en` low returns it to idle.
- R8: `clk_run` and `blocks_on` are high exactly in idle and running. `seq_on` is high exactly in running.
- R9: For each request, one cycle later `rsp_valid` pulses for one cycle, with `rsp_err` showing whether the request was rejected. A granted request also pulses `fwd_valid` in that same cycle, with its address, data and write flag. The access decision uses the state held before the edge, and `req_ready` stays high.
- R10: Priority is: power loss, then hard reset, then the other transitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | All supplies stable |
| hard_rst | input | 1 | Sensor hard reset, synchronous, active high |
| upload_done | input | 1 | Reserved-register upload finished |
| logic_en | input | 1 | Enable functional logic blocks |
| seq_en | input | 1 | Enable frame sequencer |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Always high, so requests are never stalled |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register address |
| req_data | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response pulse, one cycle after the request |
| rsp_err | output | 1 | The request was rejected |
| fwd_valid | output | 1 | Granted access forwarded |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_data | output | DATA_W | Forwarded data |
| state_code | output | 3 | Current state code (0 to 5) |
| clk_run | output | 1 | Clock enable |
| blocks_on | output | 1 | Functional block enable |
| seq_on | output | 1 | Sequencer enable |

## Verification
The bench walks the state graph through a scripted sequence and, in each state, sends addresses just below and exactly at the limit. This separates the states with limited access from those with full access, and shows the effect of an off-by-one comparison.

It also drives the following patterns:
- Enables that are held steady while a higher-priority event occurs (hard reset during running, power loss during standby). These show whether the priorities are ordered correctly.
- Inputs that should be ignored (an upload in limited standby, the sequencer enable in full standby). These confirm that those transitions are guarded.
- Both read and write requests carrying distinct data. These show whether the forwarded access is passed on faithfully.

// File: rtl/sss_pkg.sv
package sss_pkg;
  typedef enum logic [2:0] {
    ST_OFF       = 3'd0,
    ST_STBY_LIM  = 3'd1,
    ST_STBY_DEF  = 3'd2,
    ST_STBY_FULL = 3'd3,
    ST_IDLE      = 3'd4,
    ST_RUN       = 3'd5
  } sss_state_e;

  function automatic logic all_regs_open(sss_state_e s);
    return (s == ST_STBY_FULL) || (s == ST_IDLE) || (s == ST_RUN);
  endfunction

  function automatic logic low_regs_open(sss_state_e s);
    return (s == ST_STBY_LIM) || (s == ST_STBY_DEF);
  endfunction
endpackage

// File: rtl/sss_fsm.sv
module sss_fsm
  import sss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_good,
  input  logic       hard_rst,
  input  logic       upload_done,
  input  logic       logic_en,
  input  logic       seq_en,
  output sss_state_e st_q
);
  sss_state_e st_d;

  always_comb begin
    st_d = st_q;
    if (!pwr_good) begin
      st_d = ST_OFF;
    end else if (st_q == ST_OFF) begin
      st_d = ST_STBY_LIM;
    end else if (hard_rst) begin
      st_d = ST_STBY_DEF;
    end else begin
      unique case (st_q)
        ST_STBY_LIM:  st_d = ST_STBY_LIM;
        ST_STBY_DEF:  if (upload_done) st_d = ST_STBY_FULL;
        ST_STBY_FULL: if (logic_en) st_d = ST_IDLE;
        ST_IDLE: begin
          if (!logic_en)   st_d = ST_STBY_FULL;
          else if (seq_en) st_d = ST_RUN;
        end
        ST_RUN:       if (!seq_en) st_d = ST_IDLE;
        default:      st_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_OFF;
    else        st_q <= st_d;
  end

  // R2 / R10: power loss wins over everything
  assert_pwr_loss_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> st_q == ST_OFF);

  // R4: hard reset from any powered state
  assert_hard_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && hard_rst && st_q != ST_OFF) |=> st_q == ST_STBY_DEF);

  // R5: upload completion opens full standby
  assert_upload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && !hard_rst && upload_done && st_q == ST_STBY_DEF) |=> st_q == ST_STBY_FULL);

  // R7: running is only ever entered from idle
  assert_run_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_RUN && st_q != ST_IDLE) |=> st_q != ST_RUN);

  // R7: sequencer drop leaves running for idle
  assert_run_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && pwr_good && !hard_rst && !seq_en) |=> st_q == ST_IDLE);
endmodule

// File: rtl/sss_gate.sv
module sss_gate
  import sss_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 16,
  parameter int LOW_LIMIT = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  sss_state_e        st_q,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic              fwd_valid,
  output logic              fwd_write,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data
);
  localparam logic [ADDR_W-1:0] LIMIT_A = ADDR_W'(LOW_LIMIT);

  logic addr_ok;
  logic grant;

  always_comb begin
    addr_ok = all_regs_open(st_q) || (low_regs_open(st_q) && (req_addr < LIMIT_A));
    grant   = req_valid && addr_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      fwd_valid <= 1'b0;
      fwd_write <= 1'b0;
      fwd_addr  <= '0;
      fwd_data  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !addr_ok;
      fwd_valid <= grant;
      if (req_valid) begin
        fwd_write <= req_write;
        fwd_addr  <= req_addr;
        fwd_data  <= req_data;
      end
    end
  end

  // R2: nothing gets through while off
  assert_off_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && st_q == ST_OFF) |=> rsp_err && !fwd_valid);

  // R3: limited standby refuses the upper range
  assert_limit_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && st_q == ST_STBY_LIM && req_addr >= LIMIT_A) |=> rsp_err && !fwd_valid);

  // R9: full-access states forward the exact address
  assert_forward_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && all_regs_open(st_q)) |=> fwd_valid && !rsp_err && fwd_addr == $past(req_addr));
endmodule

// File: rtl/sss_enables.sv
module sss_enables
  import sss_pkg::*;
(
  input  sss_state_e st_q,
  output logic       clk_run,
  output logic       blocks_on,
  output logic       seq_on
);
  always_comb begin
    clk_run   = (st_q == ST_IDLE) || (st_q == ST_RUN);
    blocks_on = clk_run;
    seq_on    = (st_q == ST_RUN);
  end
endmodule

// File: rtl/sensor_state_ctrl.sv
module sensor_state_ctrl
  import sss_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 16,
  parameter int LOW_LIMIT = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              hard_rst,
  input  logic              upload_done,
  input  logic              logic_en,
  input  logic              seq_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic              fwd_valid,
  output logic              fwd_write,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [DATA_W-1:0] fwd_data,
  output logic [2:0]        state_code,
  output logic              clk_run,
  output logic              blocks_on,
  output logic              seq_on
);
  sss_state_e st_q;

  assign req_ready  = 1'b1;
  assign state_code = st_q;

  sss_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_good    (pwr_good),
    .hard_rst    (hard_rst),
    .upload_done (upload_done),
    .logic_en    (logic_en),
    .seq_en      (seq_en),
    .st_q        (st_q)
  );

  sss_gate #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LOW_LIMIT (LOW_LIMIT)
  ) u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_q      (st_q),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_data  (req_data),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .fwd_valid (fwd_valid),
    .fwd_write (fwd_write),
    .fwd_addr  (fwd_addr),
    .fwd_data  (fwd_data)
  );

  sss_enables u_en (
    .st_q      (st_q),
    .clk_run   (clk_run),
    .blocks_on (blocks_on),
    .seq_on    (seq_on)
  );
endmodule

// File: tb/sensor_state_ctrl_test.sv
module sensor_state_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_good = 1'b0, hard_rst = 1'b0, upload_done = 1'b0, logic_en = 1'b0, seq_en = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [8:0]  req_addr = '0;
  logic [15:0] req_data = '0;
  logic req_ready, rsp_valid, rsp_err, fwd_valid, fwd_write;
  logic [8:0]  fwd_addr;
  logic [15:0] fwd_data;
  logic [2:0]  state_code;
  logic clk_run, blocks_on, seq_on;
  int n_tests = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  sensor_state_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .hard_rst(hard_rst),
    .upload_done(upload_done), .logic_en(logic_en), .seq_en(seq_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_data(req_data), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .fwd_valid(fwd_valid), .fwd_write(fwd_write),
    .fwd_addr(fwd_addr), .fwd_data(fwd_data), .state_code(state_code),
    .clk_run(clk_run), .blocks_on(blocks_on), .seq_on(seq_on)
  );

  typedef struct packed {
    logic       pg, hr, up, le, se, rv, rw;
    logic [8:0] addr;
    logic [15:0] data;
    logic [2:0] st;
    logic       err;
    logic       fwd;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,9'd5,  16'h0000,3'd0,1'b1,1'b0}, // R2 off rejects
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,9'd0,  16'h0000,3'd1,1'b0,1'b0}, // R3 power up
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,9'd39, 16'h1111,3'd1,1'b0,1'b1}, // R3 below limit
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,9'd40, 16'h2222,3'd1,1'b1,1'b0}, // R3 at limit
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,9'd0,  16'h0000,3'd2,1'b0,1'b0}, // R4 hard reset
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,9'd100,16'h0000,3'd2,1'b1,1'b0}, // R4 high addr refused
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,9'd10, 16'hA5A5,3'd2,1'b0,1'b1}, // R4 low addr ok
    '{1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,9'd0,  16'h0000,3'd3,1'b0,1'b0}, // R5 upload
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,9'd200,16'h5A5A,3'd3,1'b0,1'b1}, // R5 full access
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,9'd0,  16'h0000,3'd4,1'b0,1'b0}, // R6 to idle
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,9'd0,  16'h0000,3'd5,1'b0,1'b0}, // R7 to running
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,9'd300,16'h0F0F,3'd5,1'b0,1'b1}, // R5 running access
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,9'd0,  16'h0000,3'd4,1'b0,1'b0}, // R7 back to idle
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,9'd40, 16'h3333,3'd3,1'b0,1'b1}, // R6 back to full standby
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,9'd0,  16'h0000,3'd4,1'b0,1'b0}, // R6
    '{1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,9'd0,  16'h0000,3'd5,1'b0,1'b0}, // R7
    '{1'b1,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,9'd0,  16'h0000,3'd2,1'b0,1'b0}, // R10 hard reset beats enables
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,9'd1,  16'h0000,3'd0,1'b0,1'b1}  // R10 power loss beats hard reset
  };

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_enables(input logic [2:0] st);
    check("R8", "clk_run",   32'(clk_run),   32'(st == 3'd4 || st == 3'd5));
    check("R8", "blocks_on", 32'(blocks_on), 32'(st == 3'd4 || st == 3'd5));
    check("R8", "seq_on",    32'(seq_on),    32'(st == 3'd5));
  endtask

  task automatic drive(input logic pg, hr, up, le, se, rv, rw, input logic [8:0] a, input logic [15:0] d);
    pwr_good = pg; hard_rst = hr; upload_done = up; logic_en = le; seq_en = se;
    req_valid = rv; req_write = rw; req_addr = a; req_data = d;
  endtask

  initial begin
    #40000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1: reset state
    drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 9'd3, 16'h0);
    repeat (3) @(negedge clk);
    check("R1", "state in reset", 32'(state_code), 32'd0);
    check("R1", "rsp_valid in reset", 32'(rsp_valid), 32'd0);
    check("R1", "fwd_valid in reset", 32'(fwd_valid), 32'd0);
    check_enables(3'd0);
    check("R9", "req_ready", 32'(req_ready), 32'd1);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0, 16'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i].pg, TBL[i].hr, TBL[i].up, TBL[i].le, TBL[i].se,
            TBL[i].rv, TBL[i].rw, TBL[i].addr, TBL[i].data);
      @(negedge clk);
      check("R2-R10 table", $sformatf("row %0d state", i), 32'(state_code), 32'(TBL[i].st));
      check("R9", $sformatf("row %0d rsp_valid", i), 32'(rsp_valid), 32'(TBL[i].rv));
      check("R9", $sformatf("row %0d rsp_err", i), 32'(rsp_err), 32'(TBL[i].err));
      check("R9", $sformatf("row %0d fwd_valid", i), 32'(fwd_valid), 32'(TBL[i].fwd));
      if (TBL[i].fwd) begin
        check("R9", $sformatf("row %0d fwd_addr", i), 32'(fwd_addr), 32'(TBL[i].addr));
        check("R9", $sformatf("row %0d fwd_data", i), 32'(fwd_data), 32'(TBL[i].data));
        check("R9", $sformatf("row %0d fwd_write", i), 32'(fwd_write), 32'(TBL[i].rw));
      end
      check_enables(TBL[i].st);
    end

    // R4: upload ignored in limited standby
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0, 16'h0);
    @(negedge clk);
    check("R3", "power up", 32'(state_code), 32'd1);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 9'd41, 16'h0);
    @(negedge clk);
    check("R4", "upload ignored in limited standby", 32'(state_code), 32'd1);
    check("R4", "still limited after upload", 32'(rsp_err), 32'd1);
    // to full standby, then R6: seq_en ignored there
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0, 16'h0);
    @(negedge clk);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0, 16'h0);
    @(negedge clk);
    check("R5", "full standby", 32'(state_code), 32'd3);
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 9'd0, 16'h0);
    repeat (2) @(negedge clk);
    check("R6", "seq_en ignored in full standby", 32'(state_code), 32'd3);
    check_enables(3'd3);
    // R2: power loss from full standby with a request pending
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 9'd0, 16'hBEEF);
    @(negedge clk);
    check("R2", "power loss state", 32'(state_code), 32'd0);
    check("R2", "request with old state granted", 32'(fwd_valid), 32'd1);
    @(negedge clk);
    check("R2", "off rejects", 32'(rsp_err), 32'd1);
    check("R9", "one response per request cycle", 32'(rsp_valid), 32'd1);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0, 16'h0);
    @(negedge clk);
    check("R9", "response is a pulse", 32'(rsp_valid), 32'd0);
    // R1: mid-run reset
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 9'd0, 16'h0);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "async reset to off", 32'(state_code), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule